// File: doc/BRIEF.md
# Bus Cycle Trace Recorder with Trigger and Breakpoint

This block sits beside a processor bus and records every qualified bus cycle (address, data and a small status field) into a circular trace memory. Recording runs without pause, overwriting the oldest entries, until a programmable trigger pattern appears on the bus. Each field of the pattern has a per-bit care mask, so a trigger can test an address and a cycle type while ignoring data. A typical pattern is a read of the exception vector word at address 0x00000078.

After the trigger the recorder keeps storing a programmed number of further cycles and then freezes. The trigger entry therefore lands anywhere in the buffer. With a count of zero it is the newest entry. With a count of DEPTH-1 it is the oldest entry, so nothing is overwritten. A value between the two keeps history on both sides. The index of the trigger entry is held for readback. A second comparator, fully independent of the trace logic, raises a one-clock break pulse for the logic that forces entry into the debug monitor. An arm pulse restarts recording without erasing stored entries.

Top module: `bus_trace_capture`

## Requirements
- R1: After reset `triggered`, `done` and `break_out` are 0, `wr_ptr` is 0, and the recorder is waiting for a trigger.
- R2: Each accepted cycle (`cyc_valid`=1, no `arm`, not done) is stored at index `wr_ptr`, and `wr_ptr` steps by one per accepted cycle, wrapping from DEPTH-1 to 0 so the oldest entry is overwritten. `rd_addr`/`rd_data`/`rd_stat` show entry `rd_idx` combinationally.
- R3: A cycle matches the trigger when, for each of address, data and status, every bit with care-mask 1 equals the value bit; mask bits at 0 are ignored. Status bit 0 is 1 for a read and 0 for a write.
- R4: A matching accepted cycle before any trigger sets `triggered` at the clock that stores it, and `trig_idx` gives the index where that cycle was stored.
- R5: `post_count` is sampled at the trigger. Exactly `post_count` further accepted cycles are stored and then `done` rises; with `post_count`=0, `done` rises with the trigger cycle itself.
- R6: While `done` is 1, bus cycles are not stored, `wr_ptr` does not move and buffer contents stay unchanged.
- R7: Matching cycles after the trigger do not move `trig_idx` and do not restart the post-trigger count.
- R8: `break_out` is 1 for exactly the clock after a valid cycle matching the break comparator (same masked rule as R3) while `brk_enable`=1, whatever the trace state; with `brk_enable`=0 it stays 0.
- R9: An `arm` pulse clears `triggered` and `done` at the next clock, keeps `wr_ptr` and the buffer, and a bus cycle presented in the same clock as `arm` is not stored.
- R10: Cycles with `cyc_valid`=0 are neither stored nor able to trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | Bus cycle present this clock |
| cyc_addr | input | ADDR_W | Bus cycle address |
| cyc_data | input | DATA_W | Bus cycle data |
| cyc_stat | input | STAT_W | Bus cycle status, bit 0 = read |
| trg_addr_val | input | ADDR_W | Trigger address pattern |
| trg_addr_care | input | ADDR_W | Trigger address care mask |
| trg_data_val | input | DATA_W | Trigger data pattern |
| trg_data_care | input | DATA_W | Trigger data care mask |
| trg_stat_val | input | STAT_W | Trigger status pattern |
| trg_stat_care | input | STAT_W | Trigger status care mask |
| post_count | input | PTR_W | Cycles stored after the trigger |
| arm | input | 1 | Restart recording pulse |
| brk_enable | input | 1 | Break comparator enable |
| brk_addr_val | input | ADDR_W | Break address pattern |
| brk_addr_care | input | ADDR_W | Break address care mask |
| brk_data_val | input | DATA_W | Break data pattern |
| brk_data_care | input | DATA_W | Break data care mask |
| brk_stat_val | input | STAT_W | Break status pattern |
| brk_stat_care | input | STAT_W | Break status care mask |
| rd_idx | input | PTR_W | Buffer readback index |
| rd_addr | output | ADDR_W | Stored address at `rd_idx` |
| rd_data | output | DATA_W | Stored data at `rd_idx` |
| rd_stat | output | STAT_W | Stored status at `rd_idx` |
| triggered | output | 1 | Trigger seen since arm/reset |
| done | output | 1 | Recording frozen |
| wr_ptr | output | PTR_W | Next index to be written |
| trig_idx | output | PTR_W | Index of the trigger entry |
| break_out | output | 1 | One-clock break request |

## Verification
The trigger comparator is tried with a write to the vector address and with a read of it carrying arbitrary data. The first must not match and the second must, which separates the care masks from plain equality. Long runs with no trigger and idle cycles carrying the trigger pattern show the wrap and the valid qualification. Post-trigger counts of 0, 8 and DEPTH-1 place the trigger entry at the newest, middle and oldest position, and a full readback shows that nothing at or after the trigger is overwritten. Break cycles are issued while the recorder is frozen and again with the comparator disabled, to show that the break path does not depend on trace state.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    CAP_PRE  = 2'd0,
    CAP_POST = 2'd1,
    CAP_DONE = 2'd2
  } cap_state_e;

  // masked compare: bits with care=1 must agree
  function automatic logic masked_eq(logic [63:0] bus, logic [63:0] val,
                                     logic [63:0] care);
    return ((bus ^ val) & care) == 64'd0;
  endfunction

  // ring successor for any depth
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/cycle_matcher.sv
module cycle_matcher
  import trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STAT_W = 4
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [STAT_W-1:0] stat,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic [ADDR_W-1:0] addr_care,
  input  logic [DATA_W-1:0] data_val,
  input  logic [DATA_W-1:0] data_care,
  input  logic [STAT_W-1:0] stat_val,
  input  logic [STAT_W-1:0] stat_care,
  output logic              hit
);
  logic addr_ok, data_ok, stat_ok;

  always_comb begin
    addr_ok = masked_eq(64'(addr), 64'(addr_val), 64'(addr_care));
    data_ok = masked_eq(64'(data), 64'(data_val), 64'(data_care));
    stat_ok = masked_eq(64'(stat), 64'(stat_val), 64'(stat_care));
    hit     = valid && addr_ok && data_ok && stat_ok;
  end
endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
  parameter int WIDTH = 68,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_word,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
  end

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign rd_word = mem[rd_idx];
    end else begin : g_odd
      assign rd_word = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;
    end
  endgenerate

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < DEPTH)); // R2
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import trace_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_valid,
  input  logic             trig_hit,
  input  logic             arm,
  input  logic [PTR_W-1:0] post_count,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] trig_idx,
  output logic             triggered,
  output logic             done
);
  cap_state_e       state;
  logic [PTR_W-1:0] remain;
  logic             accept;
  logic             trig_event;
  logic [PTR_W-1:0] ptr_succ;

  always_comb begin
    accept     = cyc_valid && !arm && (state != CAP_DONE);
    trig_event = accept && (state == CAP_PRE) && trig_hit;
    wr_en      = accept;
    ptr_succ   = PTR_W'(ring_next(32'(wr_ptr), DEPTH));
    triggered  = (state != CAP_PRE);
    done       = (state == CAP_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= CAP_PRE;
      wr_ptr   <= '0;
      trig_idx <= '0;
      remain   <= '0;
    end else if (arm) begin
      state <= CAP_PRE;
    end else if (accept) begin
      wr_ptr <= ptr_succ;
      if (trig_event) begin
        trig_idx <= wr_ptr;
        remain   <= post_count;
        state    <= (post_count == '0) ? CAP_DONE : CAP_POST;
      end else if (state == CAP_POST) begin
        remain <= remain - 1'b1;
        if (remain == PTR_W'(1)) state <= CAP_DONE;
      end
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_ptr == PTR_W'(ring_next(32'($past(wr_ptr)), DEPTH)))); // R2
  AST_FROZEN_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> ($stable(wr_ptr) && done)); // R6
  AST_DONE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> triggered); // R5
  AST_TRIG_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> ($stable(trig_idx) && triggered)); // R7
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!triggered && !done && $stable(wr_ptr))); // R9
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> !wr_en); // R10
endmodule

// File: rtl/bus_trace_capture.sv
module bus_trace_capture
  import trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STAT_W = 4,
  parameter int DEPTH  = 16,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENTRY_W = ADDR_W + DATA_W + STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_data,
  input  logic [STAT_W-1:0] cyc_stat,
  input  logic [ADDR_W-1:0] trg_addr_val,
  input  logic [ADDR_W-1:0] trg_addr_care,
  input  logic [DATA_W-1:0] trg_data_val,
  input  logic [DATA_W-1:0] trg_data_care,
  input  logic [STAT_W-1:0] trg_stat_val,
  input  logic [STAT_W-1:0] trg_stat_care,
  input  logic [PTR_W-1:0]  post_count,
  input  logic              arm,
  input  logic              brk_enable,
  input  logic [ADDR_W-1:0] brk_addr_val,
  input  logic [ADDR_W-1:0] brk_addr_care,
  input  logic [DATA_W-1:0] brk_data_val,
  input  logic [DATA_W-1:0] brk_data_care,
  input  logic [STAT_W-1:0] brk_stat_val,
  input  logic [STAT_W-1:0] brk_stat_care,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  output logic              triggered,
  output logic              done,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  trig_idx,
  output logic              break_out
);
  logic               trig_hit;
  logic               brk_hit;
  logic               wr_en;
  logic [ENTRY_W-1:0] wr_word;
  logic [ENTRY_W-1:0] rd_word;

  cycle_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_trig_cmp (
    .valid(cyc_valid), .addr(cyc_addr), .data(cyc_data), .stat(cyc_stat),
    .addr_val(trg_addr_val), .addr_care(trg_addr_care),
    .data_val(trg_data_val), .data_care(trg_data_care),
    .stat_val(trg_stat_val), .stat_care(trg_stat_care),
    .hit(trig_hit)
  );

  cycle_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_brk_cmp (
    .valid(cyc_valid), .addr(cyc_addr), .data(cyc_data), .stat(cyc_stat),
    .addr_val(brk_addr_val), .addr_care(brk_addr_care),
    .data_val(brk_data_val), .data_care(brk_data_care),
    .stat_val(brk_stat_val), .stat_care(brk_stat_care),
    .hit(brk_hit)
  );

  capture_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .trig_hit(trig_hit),
    .arm(arm), .post_count(post_count), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .trig_idx(trig_idx), .triggered(triggered), .done(done)
  );

  assign wr_word = {cyc_addr, cyc_data, cyc_stat};

  trace_ram #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_ptr), .wr_word(wr_word),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  assign {rd_addr, rd_data, rd_stat} = rd_word;

  // break request: independent of trace state, registered once
  always_ff @(posedge clk) begin
    if (!rst_n) break_out <= 1'b0;
    else        break_out <= brk_enable && brk_hit;
  end

  AST_BRK_FROM_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    break_out |-> $past(cyc_valid && brk_enable)); // R8
  AST_BRK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_enable |=> !break_out); // R8
  AST_TRIG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(triggered) && !done) |-> $past(cyc_valid)); // R4
endmodule

// File: tb/bus_trace_capture_tb.sv
module bus_trace_capture_tb;
  localparam int AW = 32, DW = 32, SW = 4, DEPTH = 16, PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_valid = 1'b0;
  logic [AW-1:0] cyc_addr = '0;
  logic [DW-1:0] cyc_data = '0;
  logic [SW-1:0] cyc_stat = '0;
  logic [AW-1:0] trg_addr_val = '0, trg_addr_care = '0;
  logic [DW-1:0] trg_data_val = '0, trg_data_care = '0;
  logic [SW-1:0] trg_stat_val = '0, trg_stat_care = '0;
  logic [PW-1:0] post_count = '0;
  logic arm = 1'b0, brk_enable = 1'b0;
  logic [AW-1:0] brk_addr_val = '0, brk_addr_care = '0;
  logic [DW-1:0] brk_data_val = '0, brk_data_care = '0;
  logic [SW-1:0] brk_stat_val = '0, brk_stat_care = '0;
  logic [PW-1:0] rd_idx = '0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] rd_stat;
  logic triggered, done, break_out;
  logic [PW-1:0] wr_ptr, trig_idx;

  int checks = 0, failures = 0;
  bit finished = 0;

  // bench model built from the requirements
  logic [AW-1:0] m_addr [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  logic [SW-1:0] m_stat [DEPTH];
  int m_ptr = 0, m_state = 0, m_rem = 0, m_tidx = 0;
  bit m_brk = 0;

  bus_trace_capture #(.ADDR_W(AW), .DATA_W(DW), .STAT_W(SW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .cyc_data(cyc_data), .cyc_stat(cyc_stat),
    .trg_addr_val(trg_addr_val), .trg_addr_care(trg_addr_care),
    .trg_data_val(trg_data_val), .trg_data_care(trg_data_care),
    .trg_stat_val(trg_stat_val), .trg_stat_care(trg_stat_care),
    .post_count(post_count), .arm(arm), .brk_enable(brk_enable),
    .brk_addr_val(brk_addr_val), .brk_addr_care(brk_addr_care),
    .brk_data_val(brk_data_val), .brk_data_care(brk_data_care),
    .brk_stat_val(brk_stat_val), .brk_stat_care(brk_stat_care),
    .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_data(rd_data), .rd_stat(rd_stat),
    .triggered(triggered), .done(done), .wr_ptr(wr_ptr), .trig_idx(trig_idx),
    .break_out(break_out)
  );

  always #4 clk = ~clk; // 125 MHz

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit fits(longint bus, longint val, longint care);
    for (int b = 0; b < 64; b++)
      if (care[b] && (bus[b] != val[b])) return 0;
    return 1;
  endfunction

  // one valid bus cycle; returns after the capturing edge
  task automatic drive(logic [AW-1:0] a, logic [DW-1:0] d, logic [SW-1:0] s);
    bit t, b;
    cyc_valid = 1; cyc_addr = a; cyc_data = d; cyc_stat = s;
    t = fits(a, trg_addr_val, trg_addr_care) && fits(d, trg_data_val, trg_data_care)
        && fits(s, trg_stat_val, trg_stat_care);
    b = fits(a, brk_addr_val, brk_addr_care) && fits(d, brk_data_val, brk_data_care)
        && fits(s, brk_stat_val, brk_stat_care);
    m_brk = brk_enable && b;
    if (m_state != 2) begin
      m_addr[m_ptr] = a; m_data[m_ptr] = d; m_stat[m_ptr] = s;
      if (m_state == 0 && t) begin
        m_tidx = m_ptr;
        if (post_count == 0) m_state = 2;
        else begin m_state = 1; m_rem = int'(post_count); end
      end else if (m_state == 1) begin
        m_rem--;
        if (m_rem == 0) m_state = 2;
      end
      m_ptr = (m_ptr + 1) % DEPTH;
    end
    @(negedge clk);
    cyc_valid = 0;
  endtask

  // idle clock with the trigger pattern on the bus but no valid (R10)
  task automatic idle_pattern();
    cyc_valid = 0; cyc_addr = 32'h78; cyc_stat = 4'h1; cyc_data = 0;
    m_brk = 0;
    @(negedge clk);
  endtask

  task automatic check_status(string req);
    check(req, "triggered", triggered, m_state != 0);
    check(req, "done", done, m_state == 2);
    check(req, "wr_ptr", wr_ptr, m_ptr);
    if (m_state != 0) check(req, "trig_idx", trig_idx, m_tidx);
    check(req, "break_out", break_out, m_brk);
  endtask

  task automatic check_buffer(string req);
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = PW'(i);
      #1;
      check(req, $sformatf("addr[%0d]", i), rd_addr, m_addr[i]);
      check(req, $sformatf("data[%0d]", i), rd_data, m_data[i]);
      check(req, $sformatf("stat[%0d]", i), rd_stat, m_stat[i]);
    end
  endtask

  task automatic do_arm(bit with_cycle);
    cyc_valid = with_cycle; cyc_addr = 32'h78; cyc_data = 32'h5; cyc_stat = 4'h1;
    arm = 1;
    m_state = 0; m_brk = 0;
    @(negedge clk);
    arm = 0; cyc_valid = 0;
  endtask

  task automatic t_reset();
    check("R1", "triggered", triggered, 0);
    check("R1", "done", done, 0);
    check("R1", "wr_ptr", wr_ptr, 0);
    check("R1", "break_out", break_out, 0);
  endtask

  task automatic t_wrap();
    // trigger: read (stat bit0=1) of 0x78, data ignored
    trg_addr_val = 32'h78; trg_addr_care = '1;
    trg_stat_val = 4'h1;   trg_stat_care = 4'h1;
    trg_data_val = '0;     trg_data_care = '0;
    post_count = 4'd8;
    for (int i = 0; i < 20; i++) begin
      drive(32'h1000 + 32'(i * 4), 32'hA000_0000 + 32'(i), 4'(i * 2 + 1));
      if (i % 5 == 0) idle_pattern();
    end
    check_status("R10");
    check_status("R2");
    check_buffer("R2");
  endtask

  task automatic t_trigger_mid();
    drive(32'h78, 32'h1234, 4'h0);       // write: no trigger (R3)
    check("R3", "write ignored", triggered, 0);
    drive(32'h78, 32'hDEAD_BEEF, 4'hF);  // read, any data: trigger
    check_status("R4");
    for (int i = 0; i < 3; i++) drive(32'h2000 + 32'(i), 32'(i), 4'h1);
    drive(32'h78, 32'h0, 4'h1);          // second match ignored (R7)
    check_status("R7");
    for (int i = 0; i < 3; i++) drive(32'h3000 + 32'(i), 32'(i), 4'h3);
    check("R5", "done before last", done, 0);
    drive(32'h3100, 32'h77, 4'h1);
    check_status("R5");
    for (int i = 0; i < 3; i++) drive(32'h4000 + 32'(i), 32'hFF, 4'h1);
    check_status("R6");
    check_buffer("R6");
  endtask

  task automatic t_rearm();
    do_arm(1);
    check_status("R9");
    check_buffer("R9");
  endtask

  task automatic t_post_zero();
    post_count = 4'd0;
    drive(32'h500, 32'h1, 4'h1);
    drive(32'h78, 32'h9, 4'h5);
    check_status("R5");
    drive(32'h600, 32'h2, 4'h1);
    check_status("R6");
  endtask

  task automatic t_post_max();
    do_arm(0);
    post_count = 4'd15;
    drive(32'h78, 32'hCAFE, 4'h1);
    for (int i = 0; i < 15; i++) drive(32'h7000 + 32'(i), 32'(i), 4'h2);
    check_status("R5");
    rd_idx = PW'(m_tidx);
    #1;
    check("R5", "trigger entry kept", rd_data, 32'hCAFE);
    drive(32'h7777, 32'h1, 4'h2);
    check_buffer("R6");
  endtask

  task automatic t_break();
    brk_addr_val = 32'h2000; brk_addr_care = '1;
    brk_stat_val = 4'h0;     brk_stat_care = 4'h1;
    brk_data_val = 32'h0000_00AB; brk_data_care = 32'h0000_00FF;
    brk_enable = 1;
    drive(32'h2000, 32'h1234_56AB, 4'h0);   // while done
    check_status("R8");
    idle_pattern();
    check("R8", "pulse one clock", break_out, 0);
    drive(32'h2000, 32'h1234_56AC, 4'h0);   // data mismatch
    check("R8", "data mismatch", break_out, 0);
    drive(32'h2000, 32'h0000_00AB, 4'h1);   // read, not write
    check("R8", "status mismatch", break_out, 0);
    brk_enable = 0;
    drive(32'h2000, 32'h0000_00AB, 4'h0);
    check("R8", "disabled", break_out, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wrap();
    t_trigger_mid();
    t_rearm();
    t_post_zero();
    t_post_max();
    t_break();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule